// File: doc/BRIEF.md
# Descriptor-Chained Framebuffer DMA Fetcher

This block moves display data from memory into a display FIFO without help from software once a channel has been started. Each channel walks a linked list of four-word descriptors. It reads a descriptor, then fetches the buffer that the descriptor names as a series of fixed-length word bursts. It then follows the descriptor's link to the next descriptor and repeats. A chain in which a palette descriptor and a framebuffer descriptor point at each other alternates between the two. A descriptor that points at itself fetches the same buffer frame after frame.

Every fetched buffer word is presented on one output stream. Each word carries a channel tag, a palette tag and frame-start and frame-end interrupt pulses, all taken from the flags in the descriptor's command word. A second channel, which has its own descriptor base, serves the second half of a dual-panel display. The two channels share one memory read port through round-robin arbitration. Per-channel FIFO-full inputs hold back data bursts. A sticky per-channel underrun flag records an empty FIFO seen while the display is active.

Top module: `fb_desc_fetch`

## Requirements
- R1: A descriptor is read as a single 4-word burst at its base byte address. Its words, at byte offsets 0, 4, 8 and 12, are: link to the next descriptor, buffer source byte address, identifier (not used by the block), and command.
- R2: In the command word, bits [15:0] hold the buffer length in 32-bit words. Bit 28 flags palette data, bit 31 requests a frame-start pulse, and bit 30 requests a frame-end pulse.
- R3: The `burst_sel` values 0, 1, 2, 3 and 4 select bursts of 4, 8, 16, 32 and 64 words. Any other value selects 16. Data bursts go to consecutive addresses, source + k·4·B, and each has `mem_len` = B.
- R4: The buffer length is rounded up to a whole number of bursts, and every fetched word is delivered. A zero length fetches no data, raises no pulse, and moves straight on to the linked descriptor.
- R5: Words from a palette-flagged buffer leave with `out_pal` = 1. All other words leave with `out_pal` = 0.
- R6: After the last word of a buffer, the channel fetches the linked descriptor by itself and continues. A self-linked descriptor repeats its buffer indefinitely.
- R7: `irq_fstart` pulses together with the first word of a buffer whose start flag is set. `irq_fend` pulses together with the last fetched word of a buffer whose end flag is set.
- R8: While `fifo_full` of a channel is high, that channel issues no data burst request. Descriptor reads are not held back.
- R9: `underrun[i]` is set when `ch_en[i]`, `disp_active` and `fifo_empty[i]` are all high. It stays set until `ch_en[i]` is low at a clock edge.
- R10: With two channels enabled, both make progress through round-robin grants of the single port, and each output word carries its source channel in `out_ch`.
- R11: After reset, and once a disabled channel has completed the burst in flight, no request and no output word appear.
- R12: `mem_req` stays high, with stable `mem_addr` and `mem_len`, until `mem_ack` accepts it. After acceptance, exactly `mem_len` beats are consumed on `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Per-channel run enable; the chain starts from `desc_base` on rise |
| desc_base | input | NCH*AW | Per-channel first-descriptor byte address, channel 0 in the low bits |
| burst_sel | input | 3 | Burst length select, held constant while enabled |
| fifo_full | input | NCH | Downstream FIFO full, per channel |
| fifo_empty | input | NCH | Downstream FIFO empty, per channel |
| disp_active | input | 1 | Display is scanning visible data |
| mem_req | output | 1 | Read burst request |
| mem_addr | output | AW | Burst start byte address |
| mem_len | output | 7 | Burst length in words |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Buffer word |
| out_pal | output | 1 | Word belongs to a palette buffer |
| out_ch | output | CW | Source channel |
| irq_fstart | output | 1 | Frame-start pulse |
| irq_fend | output | 1 | Frame-end pulse |
| underrun | output | NCH | Sticky underrun flags |

## Verification
A corrupted descriptor word or a wrong beat index becomes visible at once. The next request carries the wrong address, or the next output word differs from the buffer contents, within one burst. A miscounted remaining length moves the frame-end pulse, or puts the following descriptor request in the wrong place, by the end of the current buffer. A channel that mis-tracks arbitration or loses its state shows up as a missing or misordered word in its own tagged stream, or as a request that matches neither channel's expected next address.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

  localparam int BL_W        = 7;   // burst length field, up to 64 words
  localparam int DESC_WORDS  = 4;
  localparam int FLAG_PAL    = 28;
  localparam int FLAG_FEND   = 30;
  localparam int FLAG_FSTART = 31;

  typedef enum logic [2:0] {
    CH_IDLE,
    CH_DREQ,
    CH_DWAIT,
    CH_XREQ,
    CH_XWAIT
  } ch_state_e;

  function automatic logic [2:0] burst_log2(input logic [2:0] sel);
    case (sel)
      3'd0:    burst_log2 = 3'd2;
      3'd1:    burst_log2 = 3'd3;
      3'd3:    burst_log2 = 3'd5;
      3'd4:    burst_log2 = 3'd6;
      default: burst_log2 = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/fbdma_rr.sv
module fbdma_rr #(
  parameter int N  = 2,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [CW-1:0] gidx
);

  logic [CW-1:0] last_q, last_d;

  always_comb begin
    logic found;
    int   idx;
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(last_q) + 1 + k) % N;
      if (!found && take && req[idx]) begin
        gnt[idx] = 1'b1;
        gidx     = CW'(idx);
        found    = 1'b1;
      end
    end
    last_d = found ? gidx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

endmodule

// File: rtl/fbdma_chan.sv
module fbdma_chan
  import fbdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [AW-1:0]   desc_base,
  input  logic [2:0]      burst_sel,
  input  logic            fifo_full,
  output logic            req,
  output logic [AW-1:0]   req_addr,
  output logic [BL_W-1:0] req_len,
  input  logic            gnt,
  input  logic            beat_v,
  input  logic            beat_last,
  input  logic [31:0]     beat_data,
  output logic            tag_data,
  output logic            tag_pal,
  output logic            tag_fs,
  output logic            tag_fe
);

  ch_state_e      st_q, st_d;
  logic [AW-1:0]  cur_q, cur_d, nxt_q, nxt_d, ptr_q, ptr_d;
  logic [LEN_W:0] rem_q, rem_d;
  logic [1:0]     widx_q, widx_d;
  logic           first_q, first_d;
  logic           pal_q, pal_d, fs_q, fs_d, fe_q, fe_d;

  logic [2:0]     blog;
  logic [LEN_W:0] bw, rnd;

  always_comb begin
    blog = burst_log2(burst_sel);
    bw   = (LEN_W+1)'(1) << blog;
    rnd  = (({1'b0, beat_data[LEN_W-1:0]} + bw - (LEN_W+1)'(1)) >> blog) << blog;
  end

  always_comb begin
    req      = en & ((st_q == CH_DREQ) | ((st_q == CH_XREQ) & ~fifo_full));
    req_addr = (st_q == CH_DREQ) ? cur_q : ptr_q;
    req_len  = (st_q == CH_DREQ) ? BL_W'(DESC_WORDS) : bw[BL_W-1:0];
    tag_data = (st_q == CH_XWAIT);
    tag_pal  = pal_q;
    tag_fs   = fs_q & first_q;
    tag_fe   = fe_q & (rem_q == (LEN_W+1)'(1));
  end

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    nxt_d   = nxt_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    widx_d  = widx_q;
    first_d = first_q;
    pal_d   = pal_q;
    fs_d    = fs_q;
    fe_d    = fe_q;
    case (st_q)
      CH_IDLE: begin
        if (en) begin
          cur_d = desc_base;
          st_d  = CH_DREQ;
        end
      end
      CH_DREQ: begin
        if (gnt) begin
          widx_d = '0;
          st_d   = CH_DWAIT;
        end else if (!en) begin
          st_d = CH_IDLE;
        end
      end
      CH_DWAIT: begin
        if (beat_v) begin
          widx_d = widx_q + 2'd1;
          case (widx_q)
            2'd0: nxt_d = beat_data[AW-1:0];
            2'd1: ptr_d = beat_data[AW-1:0];
            2'd3: begin
              rem_d = rnd;
              pal_d = beat_data[FLAG_PAL];
              fs_d  = beat_data[FLAG_FSTART];
              fe_d  = beat_data[FLAG_FEND];
            end
            default: ;
          endcase
          if (beat_last) begin
            if (rnd == '0) begin
              cur_d = nxt_q;
              st_d  = CH_DREQ;
            end else begin
              first_d = 1'b1;
              st_d    = CH_XREQ;
            end
          end
        end
      end
      CH_XREQ: begin
        if (gnt)      st_d = CH_XWAIT;
        else if (!en) st_d = CH_IDLE;
      end
      CH_XWAIT: begin
        if (beat_v) begin
          rem_d   = rem_q - (LEN_W+1)'(1);
          first_d = 1'b0;
          if (beat_last) begin
            ptr_d = ptr_q + (AW'(bw) << 2);
            if (rem_q == (LEN_W+1)'(1)) begin
              cur_d = nxt_q;
              st_d  = CH_DREQ;
            end else begin
              st_d = CH_XREQ;
            end
          end
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      widx_q  <= '0;
      first_q <= 1'b0;
      pal_q   <= 1'b0;
      fs_q    <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      ptr_q   <= ptr_d;
      rem_q   <= rem_d;
      widx_q  <= widx_d;
      first_q <= first_d;
      pal_q   <= pal_d;
      fs_q    <= fs_d;
      fe_q    <= fe_d;
    end
  end

  // R4
  no_rem_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_XWAIT && beat_v) |-> (rem_q != '0));

  // R6
  chain_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_XWAIT && beat_v && beat_last && rem_q == (LEN_W+1)'(1))
      |=> (st_q == CH_DREQ && cur_q == $past(nxt_q)));

endmodule

// File: rtl/fb_desc_fetch.sv
module fb_desc_fetch
  import fbdma_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int CW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*AW-1:0] desc_base,
  input  logic [2:0]        burst_sel,
  input  logic [NCH-1:0]    fifo_full,
  input  logic [NCH-1:0]    fifo_empty,
  input  logic              disp_active,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [BL_W-1:0]   mem_len,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic              out_pal,
  output logic [CW-1:0]     out_ch,
  output logic              irq_fstart,
  output logic              irq_fend,
  output logic [NCH-1:0]    underrun
);

  logic [NCH-1:0]  c_req, c_gnt, c_beat;
  logic [AW-1:0]   c_addr [NCH];
  logic [BL_W-1:0] c_len  [NCH];
  logic [NCH-1:0]  c_data, c_pal, c_fs, c_fe;
  logic [CW-1:0]   gidx;

  logic            busy_q, busy_d, reqo_q, reqo_d;
  logic [CW-1:0]   own_q, own_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [BL_W-1:0] len_q, len_d, left_q, left_d;
  logic            beat_any, beat_last;

  logic            ov_d, pal_d, fs_d, fe_d;
  logic [NCH-1:0]  urun_q, urun_d;

  fbdma_rr #(.N(NCH), .CW(CW)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .take (~busy_q),
    .req  (c_req),
    .gnt  (c_gnt),
    .gidx (gidx)
  );

  assign beat_any  = busy_q & ~reqo_q & mem_rvalid;
  assign beat_last = (left_q == BL_W'(1));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign c_beat[i] = beat_any & (own_q == CW'(i));

    fbdma_chan #(.AW(AW), .LEN_W(LEN_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[i]),
      .desc_base(desc_base[i*AW +: AW]),
      .burst_sel(burst_sel),
      .fifo_full(fifo_full[i]),
      .req      (c_req[i]),
      .req_addr (c_addr[i]),
      .req_len  (c_len[i]),
      .gnt      (c_gnt[i]),
      .beat_v   (c_beat[i]),
      .beat_last(beat_last),
      .beat_data(mem_rdata),
      .tag_data (c_data[i]),
      .tag_pal  (c_pal[i]),
      .tag_fs   (c_fs[i]),
      .tag_fe   (c_fe[i])
    );

    always_comb begin
      urun_d[i] = urun_q[i];
      if (!ch_en[i])                          urun_d[i] = 1'b0;
      else if (disp_active && fifo_empty[i]) urun_d[i] = 1'b1;
    end

    // R9
    underrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> !underrun[i]);
  end

  // memory port sequencing
  always_comb begin
    busy_d = busy_q;
    reqo_d = reqo_q;
    own_d  = own_q;
    addr_d = addr_q;
    len_d  = len_q;
    left_d = left_q;
    if (!busy_q) begin
      if (|c_gnt) begin
        busy_d = 1'b1;
        reqo_d = 1'b1;
        own_d  = gidx;
        addr_d = c_addr[gidx];
        len_d  = c_len[gidx];
        left_d = c_len[gidx];
      end
    end else if (reqo_q) begin
      if (mem_ack) reqo_d = 1'b0;
    end else if (mem_rvalid) begin
      left_d = left_q - BL_W'(1);
      if (beat_last) busy_d = 1'b0;
    end
  end

  always_comb begin
    ov_d  = beat_any & c_data[own_q];
    pal_d = ov_d & c_pal[own_q];
    fs_d  = ov_d & c_fs[own_q];
    fe_d  = ov_d & c_fe[own_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      reqo_q     <= 1'b0;
      own_q      <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      left_q     <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_pal    <= 1'b0;
      out_ch     <= '0;
      irq_fstart <= 1'b0;
      irq_fend   <= 1'b0;
      urun_q     <= '0;
    end else begin
      busy_q     <= busy_d;
      reqo_q     <= reqo_d;
      own_q      <= own_d;
      addr_q     <= addr_d;
      len_q      <= len_d;
      left_q     <= left_d;
      out_valid  <= ov_d;
      out_pal    <= pal_d;
      irq_fstart <= fs_d;
      irq_fend   <= fe_d;
      urun_q     <= urun_d;
      if (ov_d) begin
        out_data <= mem_rdata;
        out_ch   <= own_q;
      end
    end
  end

  assign mem_req  = reqo_q;
  assign mem_addr = addr_q;
  assign mem_len  = len_q;
  assign underrun = urun_q;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

  // R12
  out_from_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mem_rvalid));

  // R7
  irq_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fstart || irq_fend) |-> out_valid);

  // R5
  pal_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pal |-> out_valid);

endmodule

// File: tb/tb_fb_desc_fetch.sv
module tb_fb_desc_fetch;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef struct packed {
    logic [31:0] d;
    logic        p;
    logic        s;
    logic        e;
  } exp_t;

  logic          clk, rst_n;
  logic [1:0]    ch_en;
  logic [63:0]   desc_base;
  logic [2:0]    burst_sel;
  logic [1:0]    fifo_full, fifo_empty;
  logic          disp_active;
  logic          mem_req;
  logic [31:0]   mem_addr;
  logic [6:0]    mem_len;
  logic          mem_ack, mem_rvalid;
  logic [31:0]   mem_rdata;
  logic          out_valid, out_pal, irq_fstart, irq_fend;
  logic [31:0]   out_data;
  logic [0:0]    out_ch;
  logic [1:0]    underrun;

  fb_desc_fetch #(.NCH(2), .AW(AW), .LEN_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .desc_base(desc_base),
    .burst_sel(burst_sel), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .disp_active(disp_active), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_pal(out_pal), .out_ch(out_ch), .irq_fstart(irq_fstart),
    .irq_fend(irq_fend), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [0:2047];
  exp_t        oq0[$], oq1[$];
  logic [63:0] rq0[$], rq1[$];
  int          tests = 0, fails = 0;
  int          seen0 = 0, seen1 = 0, acks = 0;
  logic [31:0] first0;
  logic        done = 1'b0;

  logic [15:0] lfsr;
  logic        mb_busy;
  logic [31:0] mb_addr;
  int          mb_len, mb_beat;

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setdesc(input int a, input logic [31:0] nxt, input logic [31:0] src, input logic [31:0] cmd);
    mem[a>>2]     = nxt;
    mem[(a>>2)+1] = src;
    mem[(a>>2)+2] = 32'hD0000000 | 32'(a);
    mem[(a>>2)+3] = cmd;
  endtask

  task automatic build_model(input int ch, input int base, input int bsel);
    int a, b, len, r;
    logic [31:0] cmd, src;
    a = base;
    case (bsel)
      0: b = 4;  1: b = 8;  2: b = 16;  3: b = 32;  4: b = 64;
      default: b = 16;
    endcase
    for (int d = 0; d < 12; d++) begin
      src = mem[(a>>2)+1];
      cmd = mem[(a>>2)+3];
      if (ch == 0) rq0.push_back({32'(a), 32'd4}); else rq1.push_back({32'(a), 32'd4});
      len = int'(cmd[15:0]);
      r   = ((len + b - 1) / b) * b;
      for (int k = 0; k < r / b; k++) begin
        if (ch == 0) rq0.push_back({src + 32'(k*b*4), 32'(b)});
        else         rq1.push_back({src + 32'(k*b*4), 32'(b)});
      end
      for (int w = 0; w < r; w++) begin
        exp_t e;
        e.d = mem[int'(src>>2) + w];
        e.p = cmd[28];
        e.s = cmd[31] && (w == 0);
        e.e = cmd[30] && (w == r - 1);
        if (ch == 0) oq0.push_back(e); else oq1.push_back(e);
      end
      a = int'(mem[a>>2]);
    end
  endtask

  task automatic check_out();
    exp_t e;
    logic have;
    have = 1'b0;
    if (out_ch == 1'b0 && oq0.size() > 0) begin e = oq0.pop_front(); have = 1'b1; end
    if (out_ch == 1'b1 && oq1.size() > 0) begin e = oq1.pop_front(); have = 1'b1; end
    chk(have, "R6 unexpected output word", {31'd0, out_ch, out_data}, 64'd0);
    if (have) begin
      chk(out_data == e.d, "R6 buffer word", 64'(out_data), 64'(e.d));
      chk(out_pal == e.p, "R2 R5 palette tag", 64'(out_pal), 64'(e.p));
      chk({irq_fstart, irq_fend} == {e.s, e.e}, "R7 R4 frame pulses",
          64'({irq_fstart, irq_fend}), 64'({e.s, e.e}));
    end
    if (out_ch == 1'b0) begin
      if (seen0 == 0) first0 = out_data;
      seen0++;
    end else seen1++;
  endtask

  task automatic check_req();
    logic [63:0] key;
    key = {mem_addr, 25'd0, mem_len};
    if (rq0.size() > 0 && rq0[0] == key) void'(rq0.pop_front());
    else if (rq1.size() > 0 && rq1[0] == key) void'(rq1.pop_front());
    else if (mem_len == 7'd4) chk(1'b0, "R1 descriptor request", key, rq0.size() > 0 ? rq0[0] : 64'd0);
    else chk(1'b0, "R3 data burst request", key, rq0.size() > 0 ? rq0[0] : 64'd0);
    if (mem_len == 7'd4) chk(1'b1, "R1", 0, 0); else chk(1'b1, "R3", 0, 0);
  endtask

  // behavioural memory and per-clock comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack    = 1'b0;
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
      mb_busy    = 1'b0;
      lfsr       = 16'hACE1;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (out_valid) check_out();
      mem_ack    = 1'b0;
      mem_rvalid = 1'b0;
      if (mb_busy) begin
        if (lfsr[1] | lfsr[5]) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem[int'(mb_addr>>2) + mb_beat];
          mb_beat++;
          if (mb_beat == mb_len) mb_busy = 1'b0;
        end
      end else if (mem_req && (lfsr[0] | lfsr[3])) begin
        mem_ack = 1'b1;
        acks++;
        check_req();
        mb_addr = mem_addr;
        mb_len  = int'(mem_len);
        mb_beat = 0;
        mb_busy = 1'b1;
      end
    end
  end

  task automatic clear_model();
    oq0.delete(); oq1.delete(); rq0.delete(); rq1.delete();
    seen0 = 0; seen1 = 0;
  endtask

  task automatic stop_and_quiet();
    int a0, o0;
    @(negedge clk);
    ch_en = 2'b00;
    repeat (300) @(negedge clk);
    a0 = acks; o0 = seen0 + seen1;
    repeat (40) @(negedge clk);
    chk(acks == a0 && (seen0 + seen1) == o0 && !mem_req, "R11 quiet after disable",
        64'(acks - a0), 64'd0);
  endtask

  task automatic run_chain(input logic e0, input logic e1, input int b0, input int b1,
                           input int bsel, input int n);
    int t;
    @(negedge clk);
    clear_model();
    burst_sel = 3'(bsel);
    desc_base = {32'(b1), 32'(b0)};
    if (e0) build_model(0, b0, bsel);
    if (e1) build_model(1, b1, bsel);
    ch_en = {e1, e0};
    t = 0;
    while (!((!e0 || seen0 >= n) && (!e1 || seen1 >= n)) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, "R6 progress watchdog", 64'(seen0), 64'(n));
    if (e0 && e1) chk(seen0 >= n && seen1 >= n, "R10 both channels served",
                      {32'(seen0), 32'(seen1)}, {32'(n), 32'(n)});
    stop_and_quiet();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a0, t;
    rst_n = 1'b0;
    ch_en = 2'b00; desc_base = '0; burst_sel = 3'd2;
    fifo_full = 2'b00; fifo_empty = 2'b00; disp_active = 1'b0;
    for (int i = 0; i < 2048; i++) mem[i] = pat(i);
    // palette <-> framebuffer pair, self-linked frames, zero-length entry
    setdesc(32'h020, 32'h000, 32'h400, 32'h1000_0008);
    setdesc(32'h000, 32'h020, 32'h800, 32'hC000_0028);
    setdesc(32'h080, 32'h080, 32'hC00, 32'hC000_0014);
    setdesc(32'h040, 32'h040, 32'h1000, 32'h4000_0018);
    setdesc(32'h060, 32'h080, 32'h000, 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk(!mem_req && !out_valid && !irq_fstart && !irq_fend && underrun == 2'b00,
        "R11 reset state", {mem_req, out_valid, irq_fstart, irq_fend, underrun}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mem_req && !out_valid, "R11 idle when disabled", {mem_req, out_valid}, 0);

    // R6 R5: palette/framebuffer alternation at several burst sizes (R3)
    run_chain(1'b1, 1'b0, 32'h020, 0, 2, 150);
    run_chain(1'b1, 1'b0, 32'h020, 0, 0, 100);
    run_chain(1'b1, 1'b0, 32'h020, 0, 4, 200);
    run_chain(1'b1, 1'b0, 32'h020, 0, 7, 100);
    run_chain(1'b1, 1'b0, 32'h020, 0, 3, 120);
    // R6: self-linked descriptor
    run_chain(1'b1, 1'b0, 32'h080, 0, 1, 100);
    // R10: two channels
    run_chain(1'b1, 1'b1, 32'h080, 32'h040, 2, 120);
    // R4: zero-length descriptor skips to link
    run_chain(1'b1, 1'b0, 32'h060, 0, 2, 40);
    chk(first0 == pat(32'hC00 >> 2), "R4 zero length skipped", 64'(first0), 64'(pat(32'hC00 >> 2)));

    // R8: fifo full holds data bursts, not the descriptor read
    @(negedge clk);
    clear_model();
    burst_sel = 3'd2; desc_base = {32'd0, 32'h080};
    build_model(0, 32'h080, 2);
    fifo_full = 2'b01;
    a0 = acks;
    ch_en = 2'b01;
    repeat (120) @(negedge clk);
    chk(acks - a0 == 1 && seen0 == 0, "R8 data held while full",
        {32'(acks - a0), 32'(seen0)}, {32'd1, 32'd0});
    fifo_full = 2'b00;
    t = 0;
    while (seen0 < 40 && t < 5000) begin @(negedge clk); t++; end
    chk(seen0 >= 40, "R8 resumes after full", 64'(seen0), 64'd40);

    // R9: underrun flag
    fifo_empty = 2'b01; disp_active = 1'b0;
    repeat (3) @(negedge clk);
    chk(underrun[0] == 1'b0, "R9 no underrun when display idle", 64'(underrun), 0);
    disp_active = 1'b1;
    repeat (2) @(negedge clk);
    chk(underrun == 2'b01, "R9 underrun set", 64'(underrun), 64'd1);
    fifo_empty = 2'b00;
    repeat (3) @(negedge clk);
    chk(underrun[0] == 1'b1, "R9 underrun sticky", 64'(underrun), 64'd1);
    disp_active = 1'b0;
    stop_and_quiet();
    chk(underrun == 2'b00, "R9 underrun cleared by disable", 64'(underrun), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule